// File: doc/BRIEF.md
# Dual Wiper Register Bank with One-Hot Tap Select

This block keeps the tap position of two independent 64-tap resistor ladders. Each ladder has one live wiper register and four shadow data registers. A 6-bit wiper value picks one of the ladder's 64 tap switches. The switches sit at both ends of the ladder and at every junction between its 63 series segments. The block drives that choice out as a registered one-hot vector for each ladder, so at most one switch is closed at any time.

A serial front end drives a synchronous command port. Each command carries a ladder select, a shadow register select, an operation code and write data. The front end can:
- write the wiper directly,
- write any shadow register,
- read back any register,
- copy a chosen shadow register into the live wiper.

The shadow registers are plain flops that stand in for nonvolatile storage. A write to one of them raises a one-cycle `nv_write` pulse, which the front end uses to start its busy period.

Operation codes on `op`:

| Code | Operation |
| --- | --- |
| 0 | none |
| 1 | write wiper |
| 2 | read wiper |
| 3 | write shadow register |
| 4 | read shadow register |
| 5 | copy shadow register into wiper |
| 6, 7 | unused |

`arr_sel` picks ladder 0 or 1. `reg_sel` picks shadow register 0 to 3.

Top module: `wiper_bank_top`

## Requirements
- R1: Reset is active-low and synchronous. While `rst_n` is low, on each clock edge:
  - every wiper register and every shadow register clears to 0;
  - each ladder's one-hot slice becomes bit 0 only;
  - `rd_valid` and `nv_write` are low.
- R2: Write wiper (op 1) in the cycle before edge k loads `wr_data` into the selected ladder's wiper at edge k. That ladder's slice of `tap_onehot` shows bit `wr_data` alone from edge k+1.
- R3: Each ladder's 64-bit slice of `tap_onehot` has exactly one bit set in every cycle. Bit i selects tap i. Ladder a occupies bits a*64 to a*64+63.
- R4: Write shadow register (op 3) stores `wr_data` in shadow register `reg_sel` of the selected ladder. Read shadow register (op 4) returns the stored value on `rd_data`, with `rd_valid` high, in the cycle after the request. A shadow write does not move the wiper.
- R5: Copy (op 5) loads the selected ladder's wiper from its shadow register `reg_sel`. The new tap shows one cycle later, as in R2. The shadow register keeps its value.
- R6: Read wiper (op 2) returns the selected ladder's wiper value on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R7: `nv_write` is high for exactly the one cycle after each accepted op 3 and is low after every other command.
- R8: Opcodes 0, 6 and 7, and any command with `req_valid` low, change no register and no tap. They also raise neither `rd_valid` nor `nv_write`.
- R9: A command addressed to one ladder leaves the other ladder's wiper, shadow registers and tap slice unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present this cycle |
| op | input | 3 | Operation code |
| arr_sel | input | 1 | Ladder select |
| reg_sel | input | 2 | Shadow register select |
| wr_data | input | 6 | Write data (tap index) |
| rd_data | output | 6 | Read data, held between reads |
| rd_valid | output | 1 | Read data valid, one cycle |
| nv_write | output | 1 | Shadow write done pulse |
| tap_onehot | output | 128 | One-hot tap select, ladder 0 in the low 64 bits |

## Verification
Every one of the 64 tap values is written directly into each ladder in turn. After each write, the bench compares the whole one-hot slice with the value it computed and checks that the other ladder's slice has not moved. This separates a decoder that is off by one or misindexed from one that is correct.

Each of the eight shadow registers receives a distinct value, so a mix-up of `reg_sel` or `arr_sel` shows as a wrong readback. Every shadow register is then copied into its wiper, which checks the copy path against the write path.

Unused opcodes and commands with `req_valid` low are issued with data that would move the wiper. A tap or readback that stays unchanged shows the command was ignored.

// File: rtl/wiper_bank_pkg.sv
// Package: shared operation codes for the dual wiper register bank.
// Assumes a 3-bit operation field; codes 6 and 7 are unused.
package wiper_bank_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_WIPER = 3'd2,
        OP_WR_DATA  = 3'd3,
        OP_RD_DATA  = 3'd4,
        OP_XFER     = 3'd5
    } wb_op_e;

endpackage

// File: rtl/wb_cmd_decode.sv
// Module: wb_cmd_decode
// Turns one command per cycle into per-ladder write strobes, a read request
// and the registered shadow-write pulse. Assumes arr_sel values at or above
// N_ARRAYS name no ladder and are ignored.
module wb_cmd_decode
    import wiper_bank_pkg::*;
#(
    parameter int N_ARRAYS = 2,
    parameter int ARR_W    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          op,
    input  logic [ARR_W-1:0]    arr_sel,
    output logic [N_ARRAYS-1:0] wr_wiper_en,
    output logic [N_ARRAYS-1:0] wr_data_en,
    output logic [N_ARRAYS-1:0] xfer_en,
    output logic                rd_req,
    output logic                rd_wiper,
    output logic                nv_write
);

    logic arr_ok;
    logic is_wr_wiper;
    logic is_wr_data;
    logic is_xfer;
    logic is_rd_wiper;
    logic is_rd_data;

    // Classify the incoming command once.
    always_comb begin
        arr_ok      = req_valid && (int'(arr_sel) < N_ARRAYS);
        is_wr_wiper = arr_ok && (op == OP_WR_WIPER);
        is_wr_data  = arr_ok && (op == OP_WR_DATA);
        is_xfer     = arr_ok && (op == OP_XFER);
        is_rd_wiper = arr_ok && (op == OP_RD_WIPER);
        is_rd_data  = arr_ok && (op == OP_RD_DATA);
        rd_req      = is_rd_wiper || is_rd_data;
        rd_wiper    = is_rd_wiper;
    end

    // Route each write-type strobe to the addressed ladder only.
    for (genvar a = 0; a < N_ARRAYS; a++) begin : g_strobe
        always_comb begin
            wr_wiper_en[a] = is_wr_wiper && (int'(arr_sel) == a);
            wr_data_en[a]  = is_wr_data  && (int'(arr_sel) == a);
            xfer_en[a]     = is_xfer     && (int'(arr_sel) == a);
        end
    end

    // Register the shadow-write done pulse for the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) nv_write <= 1'b0;
        else        nv_write <= is_wr_data;
    end

endmodule

// File: rtl/wb_array_regs.sv
// Module: wb_array_regs
// Holds one ladder's live wiper register and its shadow data registers.
// Assumes at most one of the three strobes is high in a cycle.
module wb_array_regs #(
    parameter int REG_W  = 6,
    parameter int N_DATA = 4,
    parameter int DSEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_wiper_en,
    input  logic                    wr_data_en,
    input  logic                    xfer_en,
    input  logic [DSEL_W-1:0]       reg_sel,
    input  logic [REG_W-1:0]        wr_data,
    output logic [REG_W-1:0]        wiper_q,
    output logic [N_DATA*REG_W-1:0] data_q
);

    logic [REG_W-1:0] shadow_pick;

    // Pick the shadow register named by reg_sel for a copy.
    always_comb begin
        shadow_pick = data_q[int'(reg_sel)*REG_W +: REG_W];
    end

    // Live wiper: a direct write or a copy from a shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n)           wiper_q <= '0;
        else if (wr_wiper_en) wiper_q <= wr_data;
        else if (xfer_en)     wiper_q <= shadow_pick;
    end

    // Shadow registers, one per generate slot.
    for (genvar d = 0; d < N_DATA; d++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[d*REG_W +: REG_W] <= '0;
            else if (wr_data_en && (int'(reg_sel) == d))
                data_q[d*REG_W +: REG_W] <= wr_data;
        end
    end

endmodule

// File: rtl/wb_tap_decoder.sv
// Module: wb_tap_decoder
// Decodes a wiper value into a registered one-hot tap select. Assumes
// N_TAPS equals 2**REG_W, so every wiper value names a real tap.
module wb_tap_decoder #(
    parameter int REG_W  = 6,
    parameter int N_TAPS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  wiper,
    output logic [N_TAPS-1:0] onehot
);

    logic [N_TAPS-1:0] onehot_d;

    // One comparator per tap switch.
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        always_comb onehot_d[t] = (int'(wiper) == t);
    end

    // Register the select so no glitch reaches the switches.
    always_ff @(posedge clk) begin
        if (!rst_n) onehot <= {{(N_TAPS-1){1'b0}}, 1'b1};
        else        onehot <= onehot_d;
    end

endmodule

// File: rtl/wb_read_port.sv
// Module: wb_read_port
// Registers read data from any wiper or shadow register. Holds the last
// value between reads. Assumes arr_sel was range-checked by the decoder.
module wb_read_port #(
    parameter int N_ARRAYS = 2,
    parameter int REG_W    = 6,
    parameter int N_DATA   = 4,
    parameter int ARR_W    = 1,
    parameter int DSEL_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_req,
    input  logic                             rd_wiper,
    input  logic [ARR_W-1:0]                 arr_sel,
    input  logic [DSEL_W-1:0]                reg_sel,
    input  logic [N_ARRAYS*REG_W-1:0]        wiper_all,
    input  logic [N_ARRAYS*N_DATA*REG_W-1:0] data_all,
    output logic [REG_W-1:0]                 rd_data,
    output logic                             rd_valid
);

    logic [REG_W-1:0] rd_pick;

    // Select the addressed register.
    always_comb begin
        if (rd_wiper)
            rd_pick = wiper_all[int'(arr_sel)*REG_W +: REG_W];
        else
            rd_pick = data_all[(int'(arr_sel)*N_DATA + int'(reg_sel))*REG_W +: REG_W];
    end

    // Capture the read result and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_pick;
        end
    end

endmodule

// File: rtl/wiper_bank_top.sv
// Module: wiper_bank_top
// Dual ladder wiper register bank. Takes one command per cycle and drives
// one registered one-hot tap select per ladder. Assumes the front end
// issues at most one command per clock.
module wiper_bank_top #(
    parameter int N_ARRAYS = 2,
    parameter int REG_W    = 6,
    parameter int N_DATA   = 4,
    parameter int ARR_W    = (N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1,
    parameter int DSEL_W   = (N_DATA > 1) ? $clog2(N_DATA) : 1,
    parameter int N_TAPS   = 1 << REG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [2:0]                 op,
    input  logic [ARR_W-1:0]           arr_sel,
    input  logic [DSEL_W-1:0]          reg_sel,
    input  logic [REG_W-1:0]           wr_data,
    output logic [REG_W-1:0]           rd_data,
    output logic                       rd_valid,
    output logic                       nv_write,
    output logic [N_ARRAYS*N_TAPS-1:0] tap_onehot
);

    logic [N_ARRAYS-1:0]               wr_wiper_en;
    logic [N_ARRAYS-1:0]               wr_data_en;
    logic [N_ARRAYS-1:0]               xfer_en;
    logic                              rd_req;
    logic                              rd_wiper;
    logic [N_ARRAYS*REG_W-1:0]         wiper_all;
    logic [N_ARRAYS*N_DATA*REG_W-1:0]  data_all;

    wb_cmd_decode #(.N_ARRAYS(N_ARRAYS), .ARR_W(ARR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .op          (op),
        .arr_sel     (arr_sel),
        .wr_wiper_en (wr_wiper_en),
        .wr_data_en  (wr_data_en),
        .xfer_en     (xfer_en),
        .rd_req      (rd_req),
        .rd_wiper    (rd_wiper),
        .nv_write    (nv_write)
    );

    // One register set and one tap decoder per ladder.
    for (genvar a = 0; a < N_ARRAYS; a++) begin : g_ladder
        wb_array_regs #(.REG_W(REG_W), .N_DATA(N_DATA), .DSEL_W(DSEL_W)) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_wiper_en (wr_wiper_en[a]),
            .wr_data_en  (wr_data_en[a]),
            .xfer_en     (xfer_en[a]),
            .reg_sel     (reg_sel),
            .wr_data     (wr_data),
            .wiper_q     (wiper_all[a*REG_W +: REG_W]),
            .data_q      (data_all[a*N_DATA*REG_W +: N_DATA*REG_W])
        );

        wb_tap_decoder #(.REG_W(REG_W), .N_TAPS(N_TAPS)) u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .wiper  (wiper_all[a*REG_W +: REG_W]),
            .onehot (tap_onehot[a*N_TAPS +: N_TAPS])
        );
    end

    wb_read_port #(
        .N_ARRAYS (N_ARRAYS),
        .REG_W    (REG_W),
        .N_DATA   (N_DATA),
        .ARR_W    (ARR_W),
        .DSEL_W   (DSEL_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_wiper  (rd_wiper),
        .arr_sel   (arr_sel),
        .reg_sel   (reg_sel),
        .wiper_all (wiper_all),
        .data_all  (data_all),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/wiper_bank_chk.sv
// Module: wiper_bank_chk
// Port-level properties of the wiper bank, bound onto wiper_bank_top.
// Assumes the same parameters as the top it is bound to.
module wiper_bank_chk
    import wiper_bank_pkg::*;
#(
    parameter int N_ARRAYS = 2,
    parameter int REG_W    = 6,
    parameter int ARR_W    = 1,
    parameter int N_TAPS   = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [2:0]                 op,
    input logic [ARR_W-1:0]           arr_sel,
    input logic [REG_W-1:0]           wr_data,
    input logic                       rd_valid,
    input logic                       nv_write,
    input logic [N_ARRAYS*N_TAPS-1:0] tap_onehot
);

    logic arr_ok;
    always_comb arr_ok = req_valid && (int'(arr_sel) < N_ARRAYS);

    // R7: an accepted shadow write is followed by the done pulse
    a_r7_nv_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok && op == OP_WR_DATA) |=> nv_write);

    // R7, R8: no pulse after any other command
    a_r7_nv_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_ok && op == OP_WR_DATA) |=> !nv_write);

    // R4, R6: reads raise rd_valid one cycle later
    a_r6_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok && (op == OP_RD_WIPER || op == OP_RD_DATA)) |=> rd_valid);

    // R8: idle cycles raise no read valid
    a_r8_no_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rd_valid);

    for (genvar a = 0; a < N_ARRAYS; a++) begin : g_ladder_chk
        logic moves;
        always_comb moves = req_valid && (int'(arr_sel) == a)
                            && (op == OP_WR_WIPER || op == OP_XFER);

        // R3: exactly one tap switch per ladder
        a_r3_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_onehot[a*N_TAPS +: N_TAPS]) == 1);

        // R2: a direct write shows as the matching tap two edges later
        a_r2_tap_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (int'(arr_sel) == a) && op == OP_WR_WIPER) |=> ##1
            (tap_onehot[a*N_TAPS +: N_TAPS] == (N_TAPS'(1) << $past(wr_data, 2))));

        // R8, R9: the tap holds when nothing moved this ladder's wiper
        a_r9_tap_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !moves |=> ##1 $stable(tap_onehot[a*N_TAPS +: N_TAPS]));
    end

endmodule

bind wiper_bank_top wiper_bank_chk #(
    .N_ARRAYS (N_ARRAYS),
    .REG_W    (REG_W),
    .ARR_W    (ARR_W),
    .N_TAPS   (N_TAPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .op         (op),
    .arr_sel    (arr_sel),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .nv_write   (nv_write),
    .tap_onehot (tap_onehot)
);

// File: tb/tb_wiper_bank_top.sv
// Bench: sweeps every tap of both ladders, every shadow register and every
// copy path against a model written from the requirements.
module tb_wiper_bank_top;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 2;
    localparam int ND = 4;
    localparam int NT = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [0:0]   arr_sel = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [5:0]   wr_data = 6'd0;
    logic [5:0]   rd_data;
    logic         rd_valid;
    logic         nv_write;
    logic [127:0] tap_onehot;

    int errors = 0;
    int checks = 0;
    int m_wiper [NA];
    int m_data  [NA][ND];
    logic [5:0] s_rd;
    logic       s_rv;
    logic       s_nv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_bank_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .op         (op),
        .arr_sel    (arr_sel),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .nv_write   (nv_write),
        .tap_onehot (tap_onehot)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command from a negedge and capture outputs after the edge.
    task automatic issue(input bit v, input int o, input int a, input int r, input int d);
        req_valid = v;
        op        = 3'(o);
        arr_sel   = 1'(a);
        reg_sel   = 2'(r);
        wr_data   = 6'(d);
        @(negedge clk);
        s_rd = rd_data;
        s_rv = rd_valid;
        s_nv = nv_write;
        req_valid = 1'b0;
        op        = 3'd0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic check_taps(input string tag);
        for (int a = 0; a < NA; a++) begin
            logic [63:0] exp_sl;
            logic [63:0] act_sl;
            exp_sl = 64'd1 << m_wiper[a];
            act_sl = tap_onehot[a*NT +: NT];
            check(act_sl == exp_sl, tag, act_sl, exp_sl);
        end
    endtask

    task automatic read_wiper(input int a, input string tag);
        issue(1'b1, 2, a, 0, 0);
        check(s_rv == 1'b1, {tag, " rd_valid"}, s_rv, 1);
        check(int'(s_rd) == m_wiper[a], tag, s_rd, m_wiper[a]);
        check(s_nv == 1'b0, {tag, " nv_write"}, s_nv, 0);
    endtask

    task automatic read_data(input int a, input int r, input string tag);
        issue(1'b1, 4, a, r, 0);
        check(s_rv == 1'b1, {tag, " rd_valid"}, s_rv, 1);
        check(int'(s_rd) == m_data[a][r], tag, s_rd, m_data[a][r]);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < NA; a++) begin
            read_wiper(a, tag);
            for (int r = 0; r < ND; r++) read_data(a, r, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            m_wiper[a] = 0;
            for (int r = 0; r < ND; r++) m_data[a][r] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs while held in reset
        check_taps("R1 reset taps");
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(nv_write == 1'b0, "R1 nv_write", nv_write, 0);
        rst_n = 1'b1;
        idle();
        read_all("R1 reset readback");

        // R2, R3, R9, R6: sweep every tap on each ladder
        for (int a = 0; a < NA; a++) begin
            for (int v = 0; v < NT; v++) begin
                int val;
                val = (a == 0) ? v : (NT - 1 - v);
                issue(1'b1, 1, a, 0, val);
                m_wiper[a] = val;
                check(s_nv == 1'b0, "R7 no pulse on wiper write", s_nv, 0);
                idle();
                check_taps("R2 R3 R9 tap sweep");
                read_wiper(a, "R6 wiper readback");
            end
        end

        // R4, R7: distinct values into every shadow register
        for (int a = 0; a < NA; a++) begin
            for (int r = 0; r < ND; r++) begin
                int val;
                val = ((a * ND + r) * 7 + 5) % NT;
                issue(1'b1, 3, a, r, val);
                m_data[a][r] = val;
                check(s_nv == 1'b1, "R7 nv_write pulse", s_nv, 1);
                idle();
                check(nv_write == 1'b0, "R7 nv_write one cycle", nv_write, 0);
                check_taps("R4 shadow write keeps tap");
            end
        end
        read_all("R4 R9 shadow readback");

        // R7: back-to-back shadow writes pulse on each
        issue(1'b1, 3, 1, 2, 33);
        m_data[1][2] = 33;
        check(s_nv == 1'b1, "R7 first of pair", s_nv, 1);
        issue(1'b1, 3, 1, 2, 34);
        m_data[1][2] = 34;
        check(s_nv == 1'b1, "R7 second of pair", s_nv, 1);
        idle();
        check(nv_write == 1'b0, "R7 pair end", nv_write, 0);

        // R5: copy every shadow register into its wiper
        for (int a = 0; a < NA; a++) begin
            for (int r = 0; r < ND; r++) begin
                issue(1'b1, 5, a, r, 0);
                m_wiper[a] = m_data[a][r];
                check(s_nv == 1'b0, "R5 copy no pulse", s_nv, 0);
                idle();
                check_taps("R5 copy tap");
                read_wiper(a, "R5 copy wiper");
                read_data(a, r, "R5 shadow kept");
            end
        end

        // R8: ignored commands carrying data that would move the wiper
        for (int o = 6; o < 8; o++) begin
            issue(1'b1, o, 0, 1, 63);
            check(s_rv == 1'b0, "R8 unused op rd_valid", s_rv, 0);
            check(s_nv == 1'b0, "R8 unused op nv_write", s_nv, 0);
            idle();
            check_taps("R8 unused op tap");
        end
        issue(1'b1, 0, 1, 0, 17);
        check(s_rv == 1'b0 && s_nv == 1'b0, "R8 nop outputs", {s_rv, s_nv}, 0);
        issue(1'b0, 1, 0, 0, 17);
        check(s_rv == 1'b0, "R8 invalid rd_valid", s_rv, 0);
        issue(1'b0, 3, 1, 3, 17);
        check(s_nv == 1'b0, "R8 invalid nv_write", s_nv, 0);
        issue(1'b0, 5, 1, 0, 0);
        idle();
        check_taps("R8 invalid request tap");
        read_all("R8 state unchanged");

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < NA; a++) begin
            m_wiper[a] = 0;
            for (int r = 0; r < ND; r++) m_data[a][r] = 0;
        end
        check_taps("R1 second reset taps");
        read_all("R1 second reset readback");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule